// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's control path and decides, once per clock, whether the core enters a handler. The two possible causes are a synchronous exception, which arrives as a request with an event code, and an external interrupt. When an event is accepted, the block computes the processor state that the handler starts from. It saves the current status word, program counter and stack register into their shadow copies. It raises the block, privilege and bank bits in the status word and loads the event code register that matches the cause. It then selects the handler address, which depends on the class of the event.

The block gives the interrupt controller the current priority mask. The controller answers with a pending vector, or with no vector. Two cases change the event that is taken. An exception that arrives while events are blocked becomes a reset. A trap returns to the instruction after itself, because its saved program counter is advanced. Every result is registered. It appears one cycle after the request cycle, together with a one-cycle entry pulse, and it holds until the next entry.

Top module: `evt_entry_seq`

## Requirements
- R1: When exc_req and irq_req are both high in the same cycle, the exception is taken and the interrupt is dropped. Every taken exception raises exc_ack together with entry_pulse.
- R2: An exception is converted to a reset when either condition holds: cur_sr bit 28 (block) is set and exc_code is not 0x1E0, or exc_code is 0x000. A reset loads exp_code with 0x000, sets new_sr bits 7:4 to 0xF and sets new_pc to 0xA0000000.
- R3: Code 0x1E0 raised while cur_sr bit 28 is set is taken as an ordinary exception with handler vbr+0x100.
- R4: While cur_sr bit 28 is set, an interrupt is ignored and outputs hold, unless halt_wake is high. With halt_wake high the interrupt is taken and wake_clr pulses with entry_pulse.
- R5: ic_mask always equals cur_sr bits 7:4. If ic_valid is low, no interrupt is taken.
- R6: On every entry, saved_sr takes cur_sr, saved_pc takes cur_pc and saved_gr takes cur_r15. new_sr is cur_sr with bits 30 (privilege), 29 (bank) and 28 (block) set.
- R7: An exception loads exp_code with its code and leaves int_code unchanged. An interrupt loads int_code with ic_vector, leaves exp_code unchanged and sets new_pc to vbr+0x600.
- R8: Codes 0x040 and 0x060 vector to vbr+0x400. Every other non-reset exception vectors to vbr+0x100.
- R9: For the trap code 0x160, saved_pc is cur_pc+2.
- R10: Results appear one clock after the request cycle. entry_pulse lasts one cycle. All outputs hold when nothing is taken and read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| exc_req | input | 1 | Exception request |
| exc_code | input | 12 | Exception event code |
| irq_req | input | 1 | External interrupt request |
| halt_wake | input | 1 | Core is halted and waiting for an interrupt |
| cur_sr | input | 32 | Current status word |
| cur_pc | input | 32 | Current program counter |
| cur_r15 | input | 32 | Current stack register |
| vbr | input | 32 | Vector base |
| ic_mask | output | 4 | Priority mask sent to the interrupt controller |
| ic_valid | input | 1 | Controller has a pending vector |
| ic_vector | input | 12 | Pending interrupt vector |
| entry_pulse | output | 1 | One-cycle pulse when an entry happens |
| exc_ack | output | 1 | Clears the exception request |
| wake_clr | output | 1 | Clears the halt flag |
| new_sr | output | 32 | Status word for the handler |
| new_pc | output | 32 | Handler address |
| saved_sr | output | 32 | Shadow status word |
| saved_pc | output | 32 | Shadow program counter |
| saved_gr | output | 32 | Shadow stack register |
| exp_code | output | 12 | Exception event code register |
| int_code | output | 12 | Interrupt event code register |

## Verification
The in-design properties check the following on every cycle:
- exceptions win over interrupts;
- a blocked exception becomes a reset;
- interrupts are held off while the block bit is set, and a halted core is still woken;
- nothing is taken without a controller vector;
- the shadow copies track the values from the request cycle;
- the entry bits are raised;
- outputs are stable between entries.

Some results need the bench's scenarios, which compare every output field with a bench-side model:
- the exact handler address for each event class;
- the trap's advanced return address;
- which event code register changes and which keeps an older value across a sequence of entries.

// File: rtl/evt_entry_pkg.sv
package evt_entry_pkg;
  localparam int XLEN     = 32;
  localparam int CODE_W   = 12;
  localparam int MASK_W   = 4;
  localparam int MASK_LO  = 4;
  localparam int SR_BLK   = 28;
  localparam int SR_BANK  = 29;
  localparam int SR_PRIV  = 30;

  localparam logic [CODE_W-1:0] CODE_RESET    = 12'h000;
  localparam logic [CODE_W-1:0] CODE_TLB_LOAD = 12'h040;
  localparam logic [CODE_W-1:0] CODE_TLB_STOR = 12'h060;
  localparam logic [CODE_W-1:0] CODE_TRAP     = 12'h160;
  localparam logic [CODE_W-1:0] CODE_BLK_OK   = 12'h1E0;

  localparam logic [XLEN-1:0] OFS_GENERAL = 32'h0000_0100;
  localparam logic [XLEN-1:0] OFS_TLB     = 32'h0000_0400;
  localparam logic [XLEN-1:0] OFS_IRQ     = 32'h0000_0600;

  typedef enum logic [2:0] {
    EV_NONE, EV_RESET, EV_GEN, EV_TLB, EV_IRQ
  } ev_kind_e;

  function automatic logic is_tlb_class(input logic [CODE_W-1:0] code);
    return (code == CODE_TLB_LOAD) || (code == CODE_TLB_STOR);
  endfunction

  function automatic logic becomes_reset(input logic [CODE_W-1:0] code,
                                         input logic blocked);
    return (code == CODE_RESET) || (blocked && (code != CODE_BLK_OK));
  endfunction

  function automatic logic [XLEN-1:0] entry_status(input logic [XLEN-1:0] sr,
                                                   input logic force_mask);
    logic [XLEN-1:0] r;
    r = sr;
    r[SR_BLK]  = 1'b1;
    r[SR_BANK] = 1'b1;
    r[SR_PRIV] = 1'b1;
    if (force_mask) r[MASK_LO +: MASK_W] = '1;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] handler_addr(input ev_kind_e kind,
                                                   input logic [XLEN-1:0] base,
                                                   input logic [XLEN-1:0] rst_addr);
    case (kind)
      EV_RESET: return rst_addr;
      EV_TLB:   return base + OFS_TLB;
      EV_IRQ:   return base + OFS_IRQ;
      default:  return base + OFS_GENERAL;
    endcase
  endfunction
endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_entry_pkg::*;
(
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              halt_wake,
  input  logic              blocked,
  input  logic              ic_valid,
  output ev_kind_e          kind,
  output logic              wake_use
);
  logic irq_ok;
  assign irq_ok = irq_req && ic_valid && (!blocked || halt_wake);

  always_comb begin
    kind     = EV_NONE;
    wake_use = 1'b0;
    if (exc_req) begin
      if (becomes_reset(exc_code, blocked)) kind = EV_RESET;
      else if (is_tlb_class(exc_code))      kind = EV_TLB;
      else                                  kind = EV_GEN;
    end else if (irq_ok) begin
      kind     = EV_IRQ;
      wake_use = halt_wake;
    end
  end
endmodule

// File: rtl/evt_state_calc.sv
module evt_state_calc
  import evt_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC  = 32'hA000_0000,
  parameter int              TRAP_STEP = 2
) (
  input  ev_kind_e          kind,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   sr,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   base,
  output logic [XLEN-1:0]   nxt_sr,
  output logic [XLEN-1:0]   nxt_spc,
  output logic [XLEN-1:0]   nxt_pc,
  output logic [CODE_W-1:0] nxt_exp
);
  logic is_trap;
  assign is_trap = (kind != EV_IRQ) && (kind != EV_RESET) && (exc_code == CODE_TRAP);

  always_comb begin
    nxt_sr  = entry_status(sr, kind == EV_RESET);
    nxt_pc  = handler_addr(kind, base, RESET_PC);
    nxt_spc = is_trap ? pc + XLEN'(TRAP_STEP) : pc;
    nxt_exp = (kind == EV_RESET) ? CODE_RESET : exc_code;
  end
endmodule

// File: rtl/evt_entry_seq.sv
module evt_entry_seq
  import evt_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC  = 32'hA000_0000,
  parameter int              TRAP_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              halt_wake,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic [XLEN-1:0]   vbr,
  output logic [MASK_W-1:0] ic_mask,
  input  logic              ic_valid,
  input  logic [CODE_W-1:0] ic_vector,
  output logic              entry_pulse,
  output logic              exc_ack,
  output logic              wake_clr,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   saved_sr,
  output logic [XLEN-1:0]   saved_pc,
  output logic [XLEN-1:0]   saved_gr,
  output logic [CODE_W-1:0] exp_code,
  output logic [CODE_W-1:0] int_code
);
  ev_kind_e          kind;
  logic              wake_use;
  logic              take;
  logic              take_exc;
  logic [XLEN-1:0]   nxt_sr, nxt_spc, nxt_pc;
  logic [CODE_W-1:0] nxt_exp;

  assign ic_mask = cur_sr[MASK_LO +: MASK_W];

  evt_arbiter u_arb (
    .exc_req   (exc_req),
    .exc_code  (exc_code),
    .irq_req   (irq_req),
    .halt_wake (halt_wake),
    .blocked   (cur_sr[SR_BLK]),
    .ic_valid  (ic_valid),
    .kind      (kind),
    .wake_use  (wake_use)
  );

  evt_state_calc #(.RESET_PC(RESET_PC), .TRAP_STEP(TRAP_STEP)) u_calc (
    .kind     (kind),
    .exc_code (exc_code),
    .sr       (cur_sr),
    .pc       (cur_pc),
    .base     (vbr),
    .nxt_sr   (nxt_sr),
    .nxt_spc  (nxt_spc),
    .nxt_pc   (nxt_pc),
    .nxt_exp  (nxt_exp)
  );

  assign take     = (kind != EV_NONE);
  assign take_exc = take && (kind != EV_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_pulse <= 1'b0;
      exc_ack     <= 1'b0;
      wake_clr    <= 1'b0;
      new_sr      <= '0;
      new_pc      <= '0;
      saved_sr    <= '0;
      saved_pc    <= '0;
      saved_gr    <= '0;
      exp_code    <= '0;
      int_code    <= '0;
    end else begin
      entry_pulse <= take;
      exc_ack     <= take_exc;
      wake_clr    <= wake_use;
      if (take) begin
        new_sr   <= nxt_sr;
        new_pc   <= nxt_pc;
        saved_sr <= cur_sr;
        saved_pc <= nxt_spc;
        saved_gr <= cur_r15;
      end
      if (take_exc)       exp_code <= nxt_exp;
      if (kind == EV_IRQ) int_code <= ic_vector;
    end
  end

  // R1
  exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (entry_pulse && exc_ack));

  // R2
  blk_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && cur_sr[SR_BLK] && exc_code != CODE_BLK_OK)
      |=> (exp_code == CODE_RESET && new_pc == RESET_PC && new_sr[MASK_LO +: MASK_W] == '1));

  // R4
  irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && cur_sr[SR_BLK] && !halt_wake) |=> !entry_pulse);

  // R4
  halt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && irq_req && ic_valid && cur_sr[SR_BLK] && halt_wake)
      |=> (entry_pulse && wake_clr && !exc_ack));

  // R5
  no_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !ic_valid) |=> !entry_pulse);

  // R6
  shadow_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pulse |-> (saved_sr == $past(cur_sr) && saved_gr == $past(cur_r15)));

  // R6
  entry_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pulse |-> (new_sr[SR_PRIV] && new_sr[SR_BANK] && new_sr[SR_BLK]));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(new_pc) && $stable(saved_pc) && $stable(exp_code) && !entry_pulse));
endmodule

// File: tb/tb_evt_entry_seq.sv
module tb_evt_entry_seq;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 0, irq_req = 0, halt_wake = 0, ic_valid = 0;
  logic [11:0] exc_code = '0, ic_vector = '0;
  logic [31:0] cur_sr = '0, cur_pc = '0, cur_r15 = '0, vbr = 32'h0C00_0000;
  logic [3:0]  ic_mask;
  logic        entry_pulse, exc_ack, wake_clr;
  logic [31:0] new_sr, new_pc, saved_sr, saved_pc, saved_gr;
  logic [11:0] exp_code, int_code;

  always #(PERIOD/2) clk = ~clk;

  evt_entry_seq dut (.*);

  typedef struct {
    logic        p, a, w;
    logic [31:0] sr, pc, ssr, spc, sgr;
    logic [11:0] ec, ic;
  } item_t;

  item_t q[$];
  string tq[$];
  item_t m;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      chk(t, "entry_pulse", 32'(entry_pulse), 32'(e.p));
      chk(t, "exc_ack",     32'(exc_ack),     32'(e.a));
      chk(t, "wake_clr",    32'(wake_clr),    32'(e.w));
      chk(t, "new_sr",      new_sr,   e.sr);
      chk(t, "new_pc",      new_pc,   e.pc);
      chk(t, "saved_sr",    saved_sr, e.ssr);
      chk(t, "saved_pc",    saved_pc, e.spc);
      chk(t, "saved_gr",    saved_gr, e.sgr);
      chk(t, "exp_code",    32'(exp_code), 32'(e.ec));
      chk(t, "int_code",    32'(int_code), 32'(e.ic));
    end
  end

  task automatic step(input logic er, input logic [11:0] ec, input logic ir,
                      input logic hw, input logic iv_ok, input logic [11:0] iv,
                      input logic [31:0] sr, input logic [31:0] pc,
                      input logic [31:0] r15, input string tag);
    logic blk, rst_like;
    @(negedge clk);
    exc_req = er; exc_code = ec; irq_req = ir; halt_wake = hw;
    ic_valid = iv_ok; ic_vector = iv; cur_sr = sr; cur_pc = pc; cur_r15 = r15;
    m.p = 0; m.a = 0; m.w = 0;
    blk = sr[28];
    if (er) begin
      m.p = 1; m.a = 1;
      m.ssr = sr; m.sgr = r15;
      m.spc = (ec == 12'h160) ? pc + 32'd2 : pc;
      m.sr = sr | 32'h7000_0000;
      rst_like = (ec == 12'h000) || (blk && ec != 12'h1E0);
      if (rst_like) begin
        m.sr = m.sr | 32'h0000_00F0;
        m.pc = 32'hA000_0000;
        m.ec = 12'h000;
        m.spc = pc;
      end else begin
        m.ec = ec;
        m.pc = (ec == 12'h040 || ec == 12'h060) ? vbr + 32'h400 : vbr + 32'h100;
      end
    end else if (ir && iv_ok && (!blk || hw)) begin
      m.p = 1; m.w = hw;
      m.ssr = sr; m.sgr = r15; m.spc = pc;
      m.sr = sr | 32'h7000_0000;
      m.ic = iv;
      m.pc = vbr + 32'h600;
    end
    q.push_back(m);
    tq.push_back(tag);
    #1;
    chk("R5", "ic_mask", 32'(ic_mask), 32'(sr[7:4]));
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m = '{default: '0};
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10", "reset entry_pulse", 32'(entry_pulse), 0);
    chk("R10", "reset new_pc", new_pc, 0);
    chk("R10", "reset saved_pc", saved_pc, 0);
    chk("R10", "reset exp_code", 32'(exp_code), 0);
    chk("R10", "reset int_code", 32'(int_code), 0);
    // R8 R7 R6 general exception
    step(1, 12'h0E0, 0, 0, 0, 0, 32'h0000_0030, 32'h0000_1000, 32'h0000_8000, "R8");
    step(0, 0, 0, 0, 0, 0, 32'h0000_0030, 32'h0000_1004, 32'h1, "R10");
    // R8 TLB class
    step(1, 12'h040, 0, 0, 0, 0, 32'h0000_0000, 32'h0000_2000, 32'h2, "R8");
    step(1, 12'h060, 0, 0, 0, 0, 32'h0000_0010, 32'h0000_2100, 32'h3, "R8");
    // R9 trap
    step(1, 12'h160, 0, 0, 0, 0, 32'h0000_0000, 32'h0000_3000, 32'h4, "R9");
    // R1 both at once
    step(1, 12'h0E0, 1, 0, 1, 12'h2A0, 32'h0000_0000, 32'h0000_3100, 32'h5, "R1");
    // R7 interrupt, exp_code keeps 0x0E0
    step(0, 0, 1, 0, 1, 12'h320, 32'h0000_0050, 32'h0000_4000, 32'h6, "R7");
    // R5 no vector
    step(0, 0, 1, 0, 0, 12'h340, 32'h0000_0000, 32'h0000_4100, 32'h7, "R5");
    // R4 blocked interrupt then halt wake
    step(0, 0, 1, 0, 1, 12'h360, 32'h1000_0000, 32'h0000_5000, 32'h8, "R4");
    step(0, 0, 1, 1, 1, 12'h380, 32'h1000_0020, 32'h0000_5100, 32'h9, "R4");
    // R2 blocked exception becomes reset
    step(1, 12'h0E0, 0, 0, 0, 0, 32'h1000_0000, 32'h0000_6000, 32'hA, "R2");
    // R3 0x1E0 under block
    step(1, 12'h1E0, 0, 0, 0, 0, 32'h1000_0000, 32'h0000_6100, 32'hB, "R3");
    // R2 reset code with block clear
    step(1, 12'h000, 0, 0, 0, 0, 32'h0000_0020, 32'h0000_6200, 32'hC, "R2");
    step(0, 0, 0, 0, 0, 0, 32'h0000_0000, 32'h0000_6300, 32'hD, "R10");
    step(0, 0, 0, 0, 0, 0, 32'h0000_0000, 32'h0000_6400, 32'hE, "R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule